// File: doc/BRIEF.md
# Floating-Point Operand Prenormalizer

This block sits in front of a floating-point calculation core. It accepts an operation code and two packed binary floating-point words per transfer. Each word has a sign, an exponent field and a fraction field, and parameters set the widths of the two fields. For each word the block works out the number class and writes the word out in an unpacked form: the sign, an unbiased two's-complement exponent that is two bits wider than the packed field, a mantissa with its leading bit made explicit, and one-hot class flags. For the requested operation it also raises an invalid-operation flag when the operand classes or signs make the result undefined.

Subnormal inputs take one of two paths, chosen by a parameter. In the first, the block counts leading zeros, shifts the fraction left until its top bit is 1, and lowers the exponent by the same amount. In the second, it replaces the subnormal with a zero that keeps the input sign. The datapath has two register stages, one for classification and one for normalization. Valid/ready handshakes on both sides control the flow.

A small controller tracks which stages hold data. It has four states: PIPE_EMPTY (neither stage full), PIPE_HEAD (only the classify stage full), PIPE_TAIL (only the output stage full) and PIPE_BOTH. The transitions are:
- fill: EMPTY to HEAD on an accept.
- drain_head: HEAD to TAIL with no new input.
- stack: HEAD to BOTH on an accept.
- retire: TAIL to EMPTY when the output is taken with no new input.
- swap: TAIL to HEAD when the output is taken and a new input arrives.
- stream: BOTH stays BOTH when the output is taken and a new input arrives.
- collapse: BOTH to TAIL when the output is taken with no new input.
- hold: any state with a full output stage stays put while the output is stalled.

Top module: `fpn_prenorm`

## Requirements
- R1: When out_valid is high, each operand's flags are one-hot with bit 0 = zero, bit 1 = finite nonzero, bit 2 = infinity and bit 3 = NaN. A word whose exponent field is neither all zeros nor all ones gives exponent = field − (2^(EXP_W−1) − 1) and mantissa = {1, fraction}.
- R2: A word with a zero exponent field and a zero fraction sets the zero flag, keeps its sign, and gives exponent 0 and mantissa 0.
- R3: With an all-ones exponent field, a zero fraction sets the infinity flag and gives exponent 0 and mantissa 0. A nonzero fraction sets the NaN flag and gives exponent 0 and mantissa {0, fraction}.
- R4: With FLUSH_DENORM = 0, a word with a zero exponent field and a nonzero fraction sets the finite flag. Its fraction is shifted left by s = MAN_W − (index of its highest set bit), so that mantissa bit MAN_W is 1, and its exponent is 1 − bias − s.
- R5: With FLUSH_DENORM = 1, such a word sets the zero flag, keeps its sign, and gives exponent 0 and mantissa 0.
- R6: The operation codes are 0 add, 1 multiply, 2 square root and 3 logarithm. Codes 2 and 3 use only operand A, and operand B is still decoded but has no effect on out_invalid. out_invalid is 1 when a used operand is NaN.
- R7: For add, out_invalid is 1 when both operands are infinite with opposite signs. For multiply, it is 1 when one operand is zero and the other is infinite.
- R8: For square root and logarithm, out_invalid is 1 when operand A is negative with the finite or infinity flag. A negative zero, including a flushed subnormal, does not raise it.
- R9: A word accepted at clock edge k is on the outputs with out_valid high after edge k+1. With out_ready held high, one word is accepted every cycle.
- R10: While out_valid is high and out_ready is low, every output holds and in_ready is low.
- R11: During and right after reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Input transfer can be taken |
| in_op | input | 2 | Operation code |
| in_a | input | EXP_W+MAN_W+1 | Packed operand A |
| in_b | input | EXP_W+MAN_W+1 | Packed operand B |
| out_valid | output | 1 | Unpacked result present |
| out_ready | input | 1 | Downstream takes the result |
| out_a_sign | output | 1 | Operand A sign |
| out_a_exp | output | EXP_W+2 | Operand A unbiased exponent, signed |
| out_a_man | output | MAN_W+1 | Operand A mantissa with explicit leading bit |
| out_a_flags | output | 4 | Operand A class, one-hot |
| out_b_sign | output | 1 | Operand B sign |
| out_b_exp | output | EXP_W+2 | Operand B unbiased exponent, signed |
| out_b_man | output | MAN_W+1 | Operand B mantissa with explicit leading bit |
| out_b_flags | output | 4 | Operand B class, one-hot |
| out_invalid | output | 1 | Invalid-operation exception |

## Verification
The assertions check on every cycle the properties that hold for any input:
- the class flags are one-hot;
- a zero carries a cleared exponent and mantissa;
- a finite result has its mantissa top bit set;
- a NaN operand A raises out_invalid;
- the outputs freeze while stalled;
- an accepted word reaches the output one cycle later.

Only the bench scenarios can show the exact values: the unbiased exponents and shifted mantissas for normal and subnormal inputs, flush-to-zero against the normalizing path, the per-operation exception rules including the operand B that is ignored for unary operations, and the double-width parameter set.

// File: rtl/fpn_pkg.sv
package fpn_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_MUL  = 2'd1,
        OP_SQRT = 2'd2,
        OP_LOG  = 2'd3
    } fpn_op_e;

    // one-hot class flag positions
    localparam int FLG_ZERO = 0;
    localparam int FLG_FIN  = 1;
    localparam int FLG_INF  = 2;
    localparam int FLG_NAN  = 3;
    localparam int FLG_W    = 4;

    // bit 1 = classify stage full, bit 0 = output stage full
    typedef enum logic [1:0] {
        PIPE_EMPTY = 2'b00,
        PIPE_TAIL  = 2'b01,
        PIPE_HEAD  = 2'b10,
        PIPE_BOTH  = 2'b11
    } fpn_pipe_e;

endpackage

// File: rtl/fpn_classify.sv
module fpn_classify
    import fpn_pkg::*;
#(
    parameter int EXP_W        = 8,
    parameter int MAN_W        = 23,
    parameter bit FLUSH_DENORM = 1'b0,
    parameter int LZW          = $clog2(MAN_W + 1)
) (
    input  logic [EXP_W+MAN_W:0] word,
    output logic [FLG_W-1:0]     flags,
    output logic                 is_sub,
    output logic [LZW-1:0]       shift
);
    logic [EXP_W-1:0] efield;
    logic [MAN_W-1:0] frac;
    logic             e_zero, e_ones, f_zero;
    logic [LZW-1:0]   lead;

    assign efield = word[EXP_W+MAN_W-1:MAN_W];
    assign frac   = word[MAN_W-1:0];
    assign e_zero = (efield == '0);
    assign e_ones = &efield;
    assign f_zero = (frac == '0);

    always_comb begin
        flags = '0;
        if (e_ones)
            flags[f_zero ? FLG_INF : FLG_NAN] = 1'b1;
        else if (e_zero && (f_zero || FLUSH_DENORM))
            flags[FLG_ZERO] = 1'b1;
        else
            flags[FLG_FIN] = 1'b1;
    end

    assign is_sub = e_zero && !f_zero && !FLUSH_DENORM;

    // position of the highest set fraction bit
    always_comb begin
        lead = '0;
        for (int i = 0; i < MAN_W; i++)
            if (frac[i]) lead = LZW'(i);
        shift = LZW'(MAN_W) - lead;
    end

endmodule

// File: rtl/fpn_normalize.sv
module fpn_normalize
    import fpn_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int LZW   = $clog2(MAN_W + 1),
    parameter int XW    = EXP_W + 2
) (
    input  logic [EXP_W-1:0]    efield,
    input  logic [MAN_W-1:0]    frac,
    input  logic [FLG_W-1:0]    flags,
    input  logic                is_sub,
    input  logic [LZW-1:0]      shift,
    output logic signed [XW-1:0] exp_o,
    output logic [MAN_W:0]      man_o
);
    localparam int BIAS = (2 ** (EXP_W - 1)) - 1;

    always_comb begin
        exp_o = '0;
        man_o = '0;
        if (flags[FLG_FIN]) begin
            if (is_sub) begin
                man_o = {1'b0, frac} << shift;
                exp_o = XW'(1 - BIAS) - XW'(shift);
            end else begin
                man_o = {1'b1, frac};
                exp_o = XW'({1'b0, efield}) - XW'(BIAS);
            end
        end else if (flags[FLG_NAN]) begin
            man_o = {1'b0, frac};
        end
    end

endmodule

// File: rtl/fpn_except.sv
module fpn_except
    import fpn_pkg::*;
(
    input  logic [1:0]       op,
    input  logic             a_sign,
    input  logic [FLG_W-1:0] a_flags,
    input  logic             b_sign,
    input  logic [FLG_W-1:0] b_flags,
    output logic             invalid
);
    logic unary, nan_hit, rule_hit;

    assign unary   = (op == OP_SQRT) || (op == OP_LOG);
    assign nan_hit = a_flags[FLG_NAN] || (!unary && b_flags[FLG_NAN]);

    always_comb begin
        rule_hit = 1'b0;
        unique case (fpn_op_e'(op))
            OP_ADD:  rule_hit = a_flags[FLG_INF] && b_flags[FLG_INF] && (a_sign ^ b_sign);
            OP_MUL:  rule_hit = (a_flags[FLG_ZERO] && b_flags[FLG_INF]) ||
                                (a_flags[FLG_INF] && b_flags[FLG_ZERO]);
            OP_SQRT,
            OP_LOG:  rule_hit = a_sign && (a_flags[FLG_FIN] || a_flags[FLG_INF]);
            default: rule_hit = 1'b0;
        endcase
    end

    assign invalid = nan_hit || rule_hit;

endmodule

// File: rtl/fpn_prenorm.sv
module fpn_prenorm
    import fpn_pkg::*;
#(
    parameter int EXP_W        = 8,
    parameter int MAN_W        = 23,
    parameter bit FLUSH_DENORM = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [1:0]               in_op,
    input  logic [EXP_W+MAN_W:0]     in_a,
    input  logic [EXP_W+MAN_W:0]     in_b,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic                     out_a_sign,
    output logic [EXP_W+1:0]         out_a_exp,
    output logic [MAN_W:0]           out_a_man,
    output logic [3:0]               out_a_flags,
    output logic                     out_b_sign,
    output logic [EXP_W+1:0]         out_b_exp,
    output logic [MAN_W:0]           out_b_man,
    output logic [3:0]               out_b_flags,
    output logic                     out_invalid
);
    localparam int WW  = EXP_W + MAN_W + 1;
    localparam int XW  = EXP_W + 2;
    localparam int LZW = $clog2(MAN_W + 1);
    localparam int NOP = 2;

    fpn_pipe_e state, state_nx;
    logic      adv, s1_full, s2_full;

    logic [WW-1:0]    in_word [NOP];
    logic [FLG_W-1:0] c_flags [NOP];
    logic             c_sub   [NOP];
    logic [LZW-1:0]   c_shift [NOP];
    logic             c_inv;

    logic [WW-1:0]    s1_word  [NOP];
    logic [FLG_W-1:0] s1_flags [NOP];
    logic             s1_sub   [NOP];
    logic [LZW-1:0]   s1_shift [NOP];
    logic             s1_inv;

    logic signed [XW-1:0] n_exp [NOP];
    logic [MAN_W:0]       n_man [NOP];

    logic                 o_sign  [NOP];
    logic signed [XW-1:0] o_exp   [NOP];
    logic [MAN_W:0]       o_man   [NOP];
    logic [FLG_W-1:0]     o_flags [NOP];
    logic                 o_inv;

    assign in_word[0] = in_a;
    assign in_word[1] = in_b;

    // ---------------- pipeline occupancy controller ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PIPE_EMPTY;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PIPE_EMPTY: state_nx = in_valid ? PIPE_HEAD : PIPE_EMPTY;               // fill
            PIPE_HEAD:  state_nx = in_valid ? PIPE_BOTH : PIPE_TAIL;                // stack / drain_head
            PIPE_TAIL:  if (out_ready) state_nx = in_valid ? PIPE_HEAD : PIPE_EMPTY; // swap / retire
            PIPE_BOTH:  if (out_ready) state_nx = in_valid ? PIPE_BOTH : PIPE_TAIL;  // stream / collapse
            default:    state_nx = PIPE_EMPTY;
        endcase
    end

    assign s1_full   = state[1];
    assign s2_full   = state[0];
    assign adv       = !s2_full || out_ready;
    assign in_ready  = adv;
    assign out_valid = s2_full;

    // ---------------- per-operand classify and normalize ----------------
    for (genvar g = 0; g < NOP; g++) begin : g_opnd
        fpn_classify #(
            .EXP_W(EXP_W), .MAN_W(MAN_W), .FLUSH_DENORM(FLUSH_DENORM), .LZW(LZW)
        ) u_cls (
            .word  (in_word[g]),
            .flags (c_flags[g]),
            .is_sub(c_sub[g]),
            .shift (c_shift[g])
        );

        fpn_normalize #(
            .EXP_W(EXP_W), .MAN_W(MAN_W), .LZW(LZW), .XW(XW)
        ) u_nrm (
            .efield(s1_word[g][WW-2:MAN_W]),
            .frac  (s1_word[g][MAN_W-1:0]),
            .flags (s1_flags[g]),
            .is_sub(s1_sub[g]),
            .shift (s1_shift[g]),
            .exp_o (n_exp[g]),
            .man_o (n_man[g])
        );

        always_ff @(posedge clk) begin
            if (adv && in_valid) begin
                s1_word[g]  <= in_word[g];
                s1_flags[g] <= c_flags[g];
                s1_sub[g]   <= c_sub[g];
                s1_shift[g] <= c_shift[g];
            end
            if (adv && s1_full) begin
                o_sign[g]  <= s1_word[g][WW-1];
                o_exp[g]   <= n_exp[g];
                o_man[g]   <= n_man[g];
                o_flags[g] <= s1_flags[g];
            end
        end
    end

    fpn_except u_exc (
        .op     (in_op),
        .a_sign (in_a[WW-1]),
        .a_flags(c_flags[0]),
        .b_sign (in_b[WW-1]),
        .b_flags(c_flags[1]),
        .invalid(c_inv)
    );

    always_ff @(posedge clk) begin
        if (adv && in_valid) s1_inv <= c_inv;
        if (adv && s1_full)  o_inv  <= s1_inv;
    end

    assign out_a_sign  = o_sign[0];
    assign out_a_exp   = o_exp[0];
    assign out_a_man   = o_man[0];
    assign out_a_flags = o_flags[0];
    assign out_b_sign  = o_sign[1];
    assign out_b_exp   = o_exp[1];
    assign out_b_man   = o_man[1];
    assign out_b_flags = o_flags[1];
    assign out_invalid = o_inv;

endmodule

// File: rtl/fpn_prenorm_chk.sv
module fpn_prenorm_chk #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [EXP_W+1:0] out_a_exp,
    input logic [MAN_W:0]   out_a_man,
    input logic [3:0]       out_a_flags,
    input logic [EXP_W+1:0] out_b_exp,
    input logic [MAN_W:0]   out_b_man,
    input logic [3:0]       out_b_flags,
    input logic             out_invalid
);
    p_flags_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_a_flags) == 1 && $countones(out_b_flags) == 1));

    p_zero_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_a_flags[0]) |-> (out_a_exp == '0 && out_a_man == '0));

    p_zero_clear_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_b_flags[0]) |-> (out_b_exp == '0 && out_b_man == '0));

    p_fin_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_a_flags[1]) |-> out_a_man[MAN_W]);

    p_nan_invalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_a_flags[3]) |-> out_invalid);

    p_accept_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> ##1 out_valid);

    p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_a_exp) && $stable(out_a_man)
            && $stable(out_a_flags) && $stable(out_b_flags) && $stable(out_invalid)));

endmodule

bind fpn_prenorm fpn_prenorm_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_a_exp  (out_a_exp),
    .out_a_man  (out_a_man),
    .out_a_flags(out_a_flags),
    .out_b_exp  (out_b_exp),
    .out_b_man  (out_b_man),
    .out_b_flags(out_b_flags),
    .out_invalid(out_invalid)
);

// File: tb/tb_fpn_prenorm.sv
module tb_fpn_prenorm;

    typedef struct packed {
        logic [1:0]         op;
        logic [31:0]        a;
        logic [31:0]        b;
        logic               inv;
        logic               a_sign;
        logic [3:0]         a_flags;
        logic signed [15:0] a_exp;
        logic [23:0]        a_man;
        logic [3:0]         b_flags;
    } vec_t;

    // flags: 1 zero, 2 finite, 4 inf, 8 NaN ; ops: 0 add 1 mul 2 sqrt 3 log
    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 32'h3F800000, 32'h40000000, 1'b0, 1'b0, 4'h2, 16'sd0,    24'h800000, 4'h2}, // R1
        '{2'd1, 32'hC0490FDB, 32'h00000000, 1'b0, 1'b1, 4'h2, 16'sd1,    24'hC90FDB, 4'h1}, // R1 R2
        '{2'd1, 32'h7F800000, 32'h80000000, 1'b1, 1'b0, 4'h4, 16'sd0,    24'h000000, 4'h1}, // R7
        '{2'd0, 32'h7F800000, 32'hFF800000, 1'b1, 1'b0, 4'h4, 16'sd0,    24'h000000, 4'h4}, // R7
        '{2'd0, 32'h7F800000, 32'h7F800000, 1'b0, 1'b0, 4'h4, 16'sd0,    24'h000000, 4'h4}, // R7
        '{2'd2, 32'hBF800000, 32'h3F800000, 1'b1, 1'b1, 4'h2, 16'sd0,    24'h800000, 4'h2}, // R8
        '{2'd2, 32'h40800000, 32'h7FC00000, 1'b0, 1'b0, 4'h2, 16'sd2,    24'h800000, 4'h8}, // R6
        '{2'd3, 32'h80000000, 32'h00000000, 1'b0, 1'b1, 4'h1, 16'sd0,    24'h000000, 4'h1}, // R8 R2
        '{2'd3, 32'hFF800000, 32'h00000000, 1'b1, 1'b1, 4'h4, 16'sd0,    24'h000000, 4'h1}, // R8 R3
        '{2'd0, 32'h7FC00001, 32'h3F800000, 1'b1, 1'b0, 4'h8, 16'sd0,    24'h400001, 4'h2}, // R3 R6
        '{2'd0, 32'h00000001, 32'h3F800000, 1'b0, 1'b0, 4'h2, -16'sd149, 24'h800000, 4'h2}, // R4
        '{2'd1, 32'h00400000, 32'h7F7FFFFF, 1'b0, 1'b0, 4'h2, -16'sd127, 24'h800000, 4'h2}, // R4
        '{2'd0, 32'h807FFFFF, 32'h3F800000, 1'b0, 1'b1, 4'h2, -16'sd127, 24'hFFFFFE, 4'h2}, // R4
        '{2'd2, 32'h80000001, 32'h00000000, 1'b1, 1'b1, 4'h2, -16'sd149, 24'h800000, 4'h1}, // R8
        '{2'd1, 32'h00000000, 32'hFF800000, 1'b1, 1'b0, 4'h1, 16'sd0,    24'h000000, 4'h4}, // R7
        '{2'd3, 32'h3F800000, 32'hFF800000, 1'b0, 1'b0, 4'h2, 16'sd0,    24'h800000, 4'h4}  // R6
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        out_ready = 1'b1;
    logic [1:0]  in_op = 2'd0;
    logic [31:0] in_a = '0, in_b = '0;
    logic [63:0] d_a = '0, d_b = '0;

    logic        in_ready, out_valid, a_sign, b_sign, inv;
    logic [9:0]  a_exp, b_exp;
    logic [23:0] a_man, b_man;
    logic [3:0]  a_flags, b_flags;

    logic        f_ready, f_valid, f_a_sign, f_b_sign, f_inv;
    logic [9:0]  f_a_exp, f_b_exp;
    logic [23:0] f_a_man, f_b_man;
    logic [3:0]  f_a_flags, f_b_flags;

    logic        d_ready, d_valid, d_a_sign, d_b_sign, d_inv;
    logic [12:0] d_a_exp, d_b_exp;
    logic [52:0] d_a_man, d_b_man;
    logic [3:0]  d_a_flags, d_b_flags;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    fpn_prenorm dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
        .out_a_sign(a_sign), .out_a_exp(a_exp), .out_a_man(a_man), .out_a_flags(a_flags),
        .out_b_sign(b_sign), .out_b_exp(b_exp), .out_b_man(b_man), .out_b_flags(b_flags),
        .out_invalid(inv));

    fpn_prenorm #(.FLUSH_DENORM(1'b1)) dut_ftz (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(f_ready),
        .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(f_valid), .out_ready(out_ready),
        .out_a_sign(f_a_sign), .out_a_exp(f_a_exp), .out_a_man(f_a_man), .out_a_flags(f_a_flags),
        .out_b_sign(f_b_sign), .out_b_exp(f_b_exp), .out_b_man(f_b_man), .out_b_flags(f_b_flags),
        .out_invalid(f_inv));

    fpn_prenorm #(.EXP_W(11), .MAN_W(52)) dut_dbl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(d_ready),
        .in_op(in_op), .in_a(d_a), .in_b(d_b), .out_valid(d_valid), .out_ready(out_ready),
        .out_a_sign(d_a_sign), .out_a_exp(d_a_exp), .out_a_man(d_a_man), .out_a_flags(d_a_flags),
        .out_b_sign(d_b_sign), .out_b_exp(d_b_exp), .out_b_man(d_b_man), .out_b_flags(d_b_flags),
        .out_invalid(d_inv));

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // drive one word, verify latency, leave outputs valid at a negedge
    task automatic send(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        in_op = op; in_a = a; in_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b0, "R9 not yet valid", 64'(out_valid), 64'd0);
        @(negedge clk);
        check(out_valid == 1'b1, "R9 valid after two edges", 64'(out_valid), 64'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        // reset state, R11
        @(negedge clk);
        check(out_valid == 1'b0, "R11 valid in reset", 64'(out_valid), 64'd0);
        check(in_ready == 1'b1, "R11 ready in reset", 64'(in_ready), 64'd1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && in_ready == 1'b1, "R11 after release",
              64'({out_valid, in_ready}), 64'b01);

        // vector table: R1 R2 R3 R4 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            send(VEC[i].op, VEC[i].a, VEC[i].b);
            check(inv == VEC[i].inv, $sformatf("R6 R7 R8 invalid vec %0d", i), 64'(inv), 64'(VEC[i].inv));
            check(a_flags == VEC[i].a_flags, $sformatf("R1 flags vec %0d", i), 64'(a_flags), 64'(VEC[i].a_flags));
            check(a_sign == VEC[i].a_sign, $sformatf("R2 sign vec %0d", i), 64'(a_sign), 64'(VEC[i].a_sign));
            check(int'($signed(a_exp)) == int'(VEC[i].a_exp), $sformatf("R1 R4 exp vec %0d", i),
                  64'($signed(a_exp)), 64'(VEC[i].a_exp));
            check(a_man == VEC[i].a_man, $sformatf("R3 R4 man vec %0d", i), 64'(a_man), 64'(VEC[i].a_man));
            check(b_flags == VEC[i].b_flags, $sformatf("R6 b flags vec %0d", i), 64'(b_flags), 64'(VEC[i].b_flags));
        end

        // max normal on operand B, R1
        send(2'd1, 32'h00400000, 32'h7F7FFFFF);
        check(int'($signed(b_exp)) == 127 && b_man == 24'hFFFFFF, "R1 max normal",
              64'({b_exp, b_man}), 64'({10'd127, 24'hFFFFFF}));

        // flush-to-zero instance, R5 and R8
        send(2'd2, 32'h807FFFFF, 32'h3F800000);
        check(f_a_flags == 4'h1 && f_a_sign == 1'b1, "R5 flushed negative", 64'({f_a_sign, f_a_flags}), 64'h11);
        check(f_a_exp == '0 && f_a_man == '0, "R5 flushed fields", 64'({f_a_exp, f_a_man}), 64'd0);
        check(f_inv == 1'b0, "R8 flushed negative sqrt", 64'(f_inv), 64'd0);
        check(inv == 1'b1 && a_flags == 4'h2, "R4 R8 normalizing path", 64'({inv, a_flags}), 64'h12);
        send(2'd0, 32'h00000001, 32'h00000000);
        check(f_a_flags == 4'h1 && f_a_sign == 1'b0, "R5 flushed positive", 64'({f_a_sign, f_a_flags}), 64'h01);

        // double-width instance, R1 R3 R4 R6
        d_a = 64'h3FF0000000000000; d_b = 64'h0000000000000001;
        send(2'd0, 32'h0, 32'h0);
        check(int'($signed(d_a_exp)) == 0 && d_a_man == 53'h10000000000000, "R1 double normal",
              64'(d_a_man), 64'h10000000000000);
        check(int'($signed(d_b_exp)) == -1074 && d_b_man == 53'h10000000000000, "R4 double subnormal",
              64'($signed(d_b_exp)), 64'(-1074));
        check(d_inv == 1'b0, "R6 double no nan", 64'(d_inv), 64'd0);
        d_a = 64'h4000000000000000; d_b = 64'hFFF8000000000000;
        send(2'd0, 32'h0, 32'h0);
        check(d_b_flags == 4'h8 && d_b_man == 53'h08000000000000, "R3 double nan",
              64'(d_b_man), 64'h08000000000000);
        check(d_inv == 1'b1, "R6 double nan invalid", 64'(d_inv), 64'd1);

        // backpressure and streaming, R10 R9
        @(negedge clk);
        out_ready = 1'b0; in_op = 2'd0; in_b = 32'h0;
        in_a = 32'h3F800000; in_valid = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R10 ready while output empty", 64'(in_ready), 64'd1);
        in_a = 32'h40000000;
        @(negedge clk);
        in_a = 32'h40400000;
        check(out_valid == 1'b1 && in_ready == 1'b0, "R10 stall blocks input",
              64'({out_valid, in_ready}), 64'b10);
        check(int'($signed(a_exp)) == 0, "R10 first word present", 64'(a_exp), 64'd0);
        @(negedge clk);
        check(out_valid == 1'b1 && int'($signed(a_exp)) == 0 && a_man == 24'h800000, "R10 held",
              64'({a_exp, a_man}), 64'h800000);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1 && int'($signed(a_exp)) == 1 && a_man == 24'h800000, "R9 second word",
              64'({a_exp, a_man}), 64'({10'd1, 24'h800000}));
        @(negedge clk);
        check(out_valid == 1'b1 && int'($signed(a_exp)) == 1 && a_man == 24'hC00000, "R9 third word next cycle",
              64'({a_exp, a_man}), 64'({10'd1, 24'hC00000}));
        @(negedge clk);
        check(out_valid == 1'b0, "R9 drained", 64'(out_valid), 64'd0);

        finish_run();
    end

endmodule